// File: doc/BRIEF.md
# Receive Collision-Window Holdback FIFO

This block sits between the byte stream coming out of an Ethernet receive MAC and the stream that feeds a DMA engine. A frame's bytes are written into the FIFO as they arrive. They stay hidden from the output side until the first collision window of that frame, 64 bytes by default, has been received. A frame that ends before the window is complete (a runt), or that sees a collision while still inside the window, is removed by moving the write pointer back to where the frame began. None of its bytes ever reach the output.

After a frame has filled its window, a committed pointer follows the write pointer, and the rest of the frame streams through. Each stored entry carries the data byte, a frame-end flag and an error flag. The output uses a valid/ready handshake. The FIFO only needs to be deep enough to cover the window plus downstream latency; it does not have to hold a whole frame. When the FIFO runs out of space, a one-cycle overflow pulse is raised. An uncommitted frame is then dropped, and a committed frame is cut short with an error terminator.

Top module: `rx_holdback_fifo`

## Requirements
- R1: After reset, out_valid and overflow are both low.
- R2: No byte of a frame is visible at the output until WINDOW bytes of it have been written. The cycle after the WINDOW-th byte is written, out_valid is high and shows the frame's first byte.
- R3: A frame that is exactly WINDOW bytes long is delivered complete, with out_last high on its final byte only.
- R4: A frame whose in_last arrives on a byte numbered below WINDOW is discarded with no output at all. The frame that follows it is delivered intact.
- R5: A collision seen on a byte numbered WINDOW or lower, or between bytes of a frame that has not yet committed, discards the frame. Input bytes are then ignored up to and including the next byte with in_last.
- R6: A collision seen after a frame has committed has no effect, and the whole frame is delivered.
- R7: Once a frame has committed, its later bytes become readable as they are written, without waiting for the end of the frame.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_last and out_error hold steady. Bytes come out in the order they were received.
- R9: Every entry that is output carries its data, the frame-end flag (out_last) and the error flag (out_error). out_error is 0 on every normal byte.
- R10: If a byte arrives while the FIFO holds DEPTH-1 entries and the frame has not yet committed, overflow pulses for one cycle. The frame is discarded and its remaining bytes, through in_last, are ignored.
- R11: If the same full condition hits a committed frame, overflow pulses and one terminator entry is appended with out_data=0, out_last=1 and out_error=1. The remaining bytes of that frame, through in_last, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | DATA_W | Received byte |
| in_last | input | 1 | This byte ends the frame |
| in_collision | input | 1 | Collision signalled for the current frame |
| out_valid | output | 1 | A committed entry is available |
| out_ready | input | 1 | Downstream accepts the entry |
| out_data | output | DATA_W | Entry data |
| out_last | output | 1 | Entry ends a frame |
| out_error | output | 1 | Entry is a truncation terminator |
| overflow | output | 1 | One-cycle pulse when a byte found no room |

## Verification
A write pointer that is not restored correctly on discard shows up at the output as stray bytes, or as bytes taken from a dropped frame. This appears as soon as the next good frame commits, one window later. A committed pointer that moves too early makes out_valid rise before the WINDOW-th byte, in the same cycle the mistake happens. One that moves too late delays the first output byte, or stalls the stream behind the window. Mistakes in occupancy or full detection change how many bytes come out before the terminator or the overflow pulse, and this is visible once the stalled FIFO is drained.

// File: rtl/rx_holdback_fifo.sv
module rx_holdback_fifo #(
  parameter int DATA_W = 8,
  parameter int WINDOW = 64,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_collision,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_error,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(WINDOW + 1);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, start_ptr, commit_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          dropping, ovf_q;

  wire [AW:0] used      = wr_ptr - rd_ptr;
  wire        room      = used < (AW+1)'(DEPTH - 1);
  wire        committed = cnt == CW'(WINDOW);
  wire        take      = in_valid && !dropping;
  wire        kill_coll = in_collision && !committed && !dropping && (in_valid || cnt != '0);
  wire        ovf       = take && !room && !kill_coll;
  wire        runt      = take && room && in_last && cnt < CW'(WINDOW - 1) && !kill_coll;
  wire        wr_byte   = take && room && !kill_coll && !runt;
  wire        we        = wr_byte || (ovf && committed);
  wire [EW-1:0] wdata   = ovf ? {1'b1, 1'b1, {DATA_W{1'b0}}} : {1'b0, in_last, in_data};
  wire        pop       = out_valid && out_ready;

  always_ff @(posedge clk)
    if (we) mem[wr_ptr[AW-1:0]] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      start_ptr  <= '0;
      commit_ptr <= '0;
      rd_ptr     <= '0;
      cnt        <= '0;
      dropping   <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_q <= ovf;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (dropping && in_valid && in_last) dropping <= 1'b0;
      if (kill_coll) begin
        wr_ptr   <= start_ptr;
        cnt      <= '0;
        dropping <= !(in_valid && in_last);
      end else if (ovf) begin
        cnt      <= '0;
        dropping <= !in_last;
        if (committed) begin
          wr_ptr     <= wr_ptr + 1'b1;
          commit_ptr <= wr_ptr + 1'b1;
          start_ptr  <= wr_ptr + 1'b1;
        end else begin
          wr_ptr <= start_ptr;
        end
      end else if (runt) begin
        wr_ptr <= start_ptr;
        cnt    <= '0;
      end else if (wr_byte) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (cnt >= CW'(WINDOW - 1)) commit_ptr <= wr_ptr + 1'b1;
        if (in_last) begin
          cnt       <= '0;
          start_ptr <= wr_ptr + 1'b1;
        end else if (!committed) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign out_valid = rd_ptr != commit_ptr;
  assign {out_error, out_last, out_data} = mem[rd_ptr[AW-1:0]];
  assign overflow  = ovf_q;
endmodule

// File: rtl/rx_holdback_fifo_chk.sv
module rx_holdback_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              out_error,
  input logic              overflow,
  input logic [AW:0]       wr_ptr,
  input logic [AW:0]       commit_ptr,
  input logic [AW:0]       rd_ptr
);
  wire [AW:0] occ  = wr_ptr - rd_ptr;
  wire [AW:0] vis  = commit_ptr - rd_ptr;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_error));

  p_terminator_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_error |-> out_last && out_data == '0);

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_valid));

  p_occupancy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(DEPTH));

  p_commit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vis <= occ);
endmodule

bind rx_holdback_fifo rx_holdback_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .out_error(out_error), .overflow(overflow), .wr_ptr(wr_ptr),
  .commit_ptr(commit_ptr), .rd_ptr(rd_ptr)
);

// File: tb/sim_rx_holdback_fifo.sv
`timescale 1ns/1ps
module sim_rx_holdback_fifo;
  localparam int DW = 8, WIN = 64, DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_collision = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_last, out_error, overflow;
  logic [DW-1:0] out_data;

  int checks = 0, failures = 0, ovf_cnt = 0;
  string cur_req = "R1";
  logic [DW+1:0] exp_q[$];

  always #4 clk = ~clk;

  rx_holdback_fifo #(.DATA_W(DW), .WINDOW(WIN), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_collision(in_collision), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_error(out_error), .overflow(overflow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (overflow) ovf_cnt++;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0)
        check(0, {cur_req, " unexpected output"}, {out_error, out_last, out_data}, 0);
      else begin
        logic [DW+1:0] e;
        e = exp_q.pop_front();
        check({out_error, out_last, out_data} == e, {cur_req, " R9 entry"}, {out_error, out_last, out_data}, e);
      end
    end
  end

  task automatic set_ready(input bit r);
    @(posedge clk); #1 out_ready = r;
  endtask

  task automatic send(input int len, input int seed, input int coll_at, input bit keep,
                      input bit with_last, input bit chk_hold);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chk_hold && i > 0 && i < WIN) check(out_valid == 0, "R2 held", out_valid, 0);
      if (chk_hold && i == WIN) check(out_valid == 1, "R2 release", out_valid, 1);
      in_valid = 1;
      in_data = DW'(seed + i);
      in_last = with_last && (i == len - 1);
      in_collision = (i == coll_at);
      if (keep) exp_q.push_back({1'b0, in_last, in_data});
    end
    @(negedge clk);
    if (chk_hold && len == WIN) check(out_valid == 1 && out_data == DW'(seed), "R2 release", out_data, seed);
    in_valid = 0; in_last = 0; in_collision = 0;
  endtask

  task automatic drain(input string req);
    set_ready(1);
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, {req, " all expected delivered"}, exp_q.size(), 0);
    check(out_valid == 0, {req, " nothing left"}, out_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0 && overflow == 0, "R1 reset", {out_valid, overflow}, 0);
    #1 rst_n = 1;
    set_ready(1);

    cur_req = "R2"; send(90, 8'h10, -1, 1, 1, 1); drain("R2");
    cur_req = "R3"; send(WIN, 8'h40, -1, 1, 1, 1); drain("R3");
    cur_req = "R4"; send(40, 8'h70, -1, 0, 1, 0); send(WIN - 1, 8'h71, -1, 0, 1, 0);
    send(70, 8'h80, -1, 1, 1, 0); drain("R4");
    cur_req = "R5"; send(80, 8'h90, 10, 0, 1, 0); send(WIN, 8'h95, WIN - 1, 0, 1, 0);
    send(30, 8'h99, -1, 0, 0, 0);
    @(negedge clk); in_collision = 1; @(negedge clk); in_collision = 0;
    send(20, 8'h9A, -1, 0, 1, 0);
    send(66, 8'hA0, -1, 1, 1, 0); drain("R5");
    cur_req = "R6"; send(100, 8'hB0, 80, 1, 1, 0); drain("R6");
    check(ovf_cnt == 0, "R10 no overflow yet", ovf_cnt, 0);

    cur_req = "R7"; set_ready(0);
    send(75, 8'hC0, -1, 1, 0, 0);
    set_ready(1);
    repeat (90) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R7 bytes before frame end", exp_q.size(), 0);
    send(1, 8'hCF, -1, 1, 1, 0); drain("R7");

    cur_req = "R10"; set_ready(0);
    send(100, 8'hD0, -1, 1, 1, 0);
    send(80, 8'hE0, -1, 0, 1, 0);
    repeat (3) @(posedge clk);
    check(ovf_cnt == 1, "R10 overflow pulse", ovf_cnt, 1);
    begin
      logic [DW+1:0] snap;
      @(negedge clk); snap = {out_error, out_last, out_data};
      repeat (3) @(negedge clk);
      check(out_valid && {out_error, out_last, out_data} == snap && snap == exp_q[0],
            "R8 stall hold", {out_error, out_last, out_data}, snap);
    end
    drain("R10");

    cur_req = "R11"; set_ready(0);
    for (int i = 0; i < DEPTH - 1; i++) exp_q.push_back({2'b00, DW'(8'h20 + i)});
    exp_q.push_back({2'b11, {DW{1'b0}}});
    send(200, 8'h20, -1, 0, 1, 0);
    repeat (3) @(posedge clk);
    check(ovf_cnt == 2, "R11 overflow pulse", ovf_cnt, 2);
    drain("R11");
    send(70, 8'h55, -1, 1, 1, 0); drain("R11 recovery");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule